// File: doc/BRIEF.md
# Programming Mode Entry Detector

This block sits beside the clock pins of a small controller and decides when the device must stop running its application and hand over to the in-system programming logic. It has no mode pin of its own. It reads the two oscillator pins and applies one of two entry rules, and the rule depends on the clock source. With an external clock source, the programmer holds the second pin low and pulses the first pin repeatedly. With the on-chip oscillator, the programmer holds the second pin low for a run of internal clock periods.

When a rule is met, the detector is armed. From that point it holds the device in reset, forces every I/O port to input, and turns the second pin into an open-drain output with a pull-up. It then waits a bounded time for the programming-voltage indication. This indication is a single digital input. If the indication arrives, the detector fires a one-cycle start pulse to the frame sequencer, enables the programming clock and stays active until the next reset. If the indication does not arrive in time, every output drops and normal operation resumes.

Top module: `isp_entry_detect`

## Requirements
- R1: After reset, isp_start, isp_active, reset_req, port_input_force, osc2_od_en and prog_clk_en are all 0.
- R2: With ext_clk_sel=1 and the synchronised osc2_in low, nine rising edges of osc1_in arm the detector. Armed means reset_req, port_input_force and osc2_od_en are 1. Eight rising edges leave these outputs at 0.
- R3: With ext_clk_sel=0 and the synchronised osc2_in low, nine int_tick pulses arm the detector. Eight pulses do not.
- R4: Before arming, osc2_in going high clears both counts. Edges or ticks seen before the clear do not count toward the nine.
- R5: Only the selected path can arm the detector. With ext_clk_sel=1, int_tick pulses do not arm it. With ext_clk_sel=0, osc1_in edges do not arm it.
- R6: A vpp_detect high while armed gives isp_start=1 for exactly one cycle, starting in the cycle after the sampling edge. isp_active and prog_clk_en then go to 1 and stay at 1 until reset, and reset_req remains 1.
- R7: If vpp_detect stays low for TIMEOUT_CYCLES clock cycles after arming, the detector returns to idle. All outputs return to 0.
- R8: A vpp_detect high while idle has no effect, and all outputs stay at 0.
- R9: osc1_in and osc2_in each pass through a two-flop synchroniser before edge detection and counting. The reference model applies the same latency, and all outputs match it on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_sel | input | 1 | 1 = external-clock entry rule, 0 = internal-oscillator rule |
| osc1_in | input | 1 | First oscillator pin level |
| osc2_in | input | 1 | Second oscillator pin level |
| int_tick | input | 1 | One-cycle pulse per internal oscillator period |
| vpp_detect | input | 1 | Digital programming-voltage indication |
| isp_start | output | 1 | One-cycle pulse to the frame sequencer |
| isp_active | output | 1 | Programming mode in force |
| reset_req | output | 1 | Hold the device in reset |
| port_input_force | output | 1 | Force all I/O ports to input |
| osc2_od_en | output | 1 | Second pin becomes open-drain with pull-up |
| prog_clk_en | output | 1 | Start the programming clock |

## Verification
The assertions assume three things about the inputs:
- vpp_detect and int_tick are already synchronous to clk.
- int_tick is a single-cycle pulse.
- osc1_in stays at each level for longer than the synchroniser depth, so no edge is lost.

The stimulus drives every input half a cycle away from the sampling edge. It holds each osc1_in level for two cycles and spaces the ticks three cycles apart. It changes ext_clk_sel only while osc2_in is high, so that a count left over from one rule can never arm the other.

// File: rtl/isp_entry_pkg.sv
package isp_entry_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_ACTIVE = 2'd2
  } entry_state_t;

  // saturating step: advance only when asked and below the ceiling
  function automatic int unsigned sat_step(int unsigned cur, int unsigned ceil_v, logic bump);
    return (bump && (cur < ceil_v)) ? cur + 1 : cur;
  endfunction

  function automatic logic at_limit(int unsigned cur, int unsigned ceil_v);
    return cur >= ceil_v;
  endfunction

  // last timer value before the wait window closes
  function automatic int unsigned last_wait(int unsigned window);
    return window - 1;
  endfunction

endpackage

// File: rtl/isp_pin_sync.sv
module isp_pin_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic pin_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  assign pin_o = chain_q[STAGES-1];

endmodule

// File: rtl/isp_run_counter.sv
module isp_run_counter
  import isp_entry_pkg::*;
#(
  parameter int LIMIT = 9,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bump,
  output logic full
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= CW'(sat_step(32'(cnt_q), LIMIT, bump));
  end

  assign full = at_limit(32'(cnt_q), LIMIT);

  // R2
  count_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) <= LIMIT);

  // R4
  count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/isp_entry_fsm.sv
module isp_entry_fsm
  import isp_entry_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 4096,
  localparam int TW = $clog2(TIMEOUT_CYCLES)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm_req,
  input  logic         vpp_detect,
  output entry_state_t state,
  output logic         start_pulse,
  output logic         timeout_evt
);

  entry_state_t  state_q, state_d;
  logic [TW-1:0] wait_q;
  logic          start_q;
  logic          vpp_evt;

  assign vpp_evt     = (state_q == ST_ARMED) && vpp_detect;
  assign timeout_evt = (state_q == ST_ARMED) && !vpp_detect &&
                       (32'(wait_q) == last_wait(TIMEOUT_CYCLES));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (arm_req) state_d = ST_ARMED;
      ST_ARMED:  if (vpp_evt) state_d = ST_ACTIVE;
                 else if (timeout_evt) state_d = ST_IDLE;
      ST_ACTIVE: state_d = ST_ACTIVE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= vpp_evt;
      if (state_q != ST_ARMED) wait_q <= '0;
      else if (!vpp_detect)    wait_q <= wait_q + 1'b1;
    end
  end

  assign state       = state_q;
  assign start_pulse = start_q;

  // R6
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  // R6
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> ($past(vpp_detect) && state == ST_ACTIVE));

  // R7
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> (state == ST_IDLE));

  // R6
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACTIVE) |=> (state == ST_ACTIVE));

endmodule

// File: rtl/isp_entry_detect.sv
module isp_entry_detect
  import isp_entry_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int TOGGLE_MIN     = 9,
  parameter int LOW_MIN        = 9,
  parameter int TIMEOUT_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk_sel,
  input  logic osc1_in,
  input  logic osc2_in,
  input  logic int_tick,
  input  logic vpp_detect,
  output logic isp_start,
  output logic isp_active,
  output logic reset_req,
  output logic port_input_force,
  output logic osc2_od_en,
  output logic prog_clk_en
);

  logic         osc1_s, osc2_s, osc1_prev;
  logic         osc1_rise, count_clr, arm_req;
  logic         tgl_full, low_full, timeout_evt;
  entry_state_t state;

  // R9
  isp_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync1 (
    .clk(clk), .rst_n(rst_n), .pin_i(osc1_in), .pin_o(osc1_s));

  isp_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync2 (
    .clk(clk), .rst_n(rst_n), .pin_i(osc2_in), .pin_o(osc2_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) osc1_prev <= 1'b0;
    else        osc1_prev <= osc1_s;
  end

  assign osc1_rise = osc1_s && !osc1_prev;
  assign count_clr = osc2_s || (state != ST_IDLE);

  isp_run_counter #(.LIMIT(TOGGLE_MIN)) u_tgl_cnt (
    .clk(clk), .rst_n(rst_n), .clr(count_clr), .bump(osc1_rise), .full(tgl_full));

  isp_run_counter #(.LIMIT(LOW_MIN)) u_low_cnt (
    .clk(clk), .rst_n(rst_n), .clr(count_clr), .bump(int_tick), .full(low_full));

  assign arm_req = !osc2_s && (ext_clk_sel ? tgl_full : low_full);

  isp_entry_fsm #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .arm_req(arm_req), .vpp_detect(vpp_detect),
    .state(state), .start_pulse(isp_start), .timeout_evt(timeout_evt));

  assign reset_req        = (state != ST_IDLE);
  assign port_input_force = (state != ST_IDLE);
  assign osc2_od_en       = (state != ST_IDLE);
  assign isp_active       = (state == ST_ACTIVE);
  assign prog_clk_en      = (state == ST_ACTIVE);

  // R2
  arm_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> $past(!osc2_s));

  // R5
  arm_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> $past(ext_clk_sel ? tgl_full : low_full));

  // R7
  drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reset_req) |-> $past(timeout_evt));

endmodule

// File: tb/isp_entry_detect_tb.sv
module isp_entry_detect_tb;

  localparam int TO = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_clk_sel = 1'b1, osc1_in = 1'b0, osc2_in = 1'b1, int_tick = 1'b0, vpp_detect = 1'b0;
  logic isp_start, isp_active, reset_req, port_input_force, osc2_od_en, prog_clk_en;

  int checks = 0, fails = 0;
  bit cmp_en = 0, done = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  isp_entry_detect #(.TIMEOUT_CYCLES(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_clk_sel(ext_clk_sel), .osc1_in(osc1_in),
    .osc2_in(osc2_in), .int_tick(int_tick), .vpp_detect(vpp_detect),
    .isp_start(isp_start), .isp_active(isp_active), .reset_req(reset_req),
    .port_input_force(port_input_force), .osc2_od_en(osc2_od_en), .prog_clk_en(prog_clk_en));

  // behavioural reference: pin histories in queues, phase as an integer
  bit q1[$], q2[$];
  bit m_prev = 0, m_start = 0;
  int m_tc = 0, m_lc = 0, m_phase = 0, m_wait = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q1 = '{0, 0}; q2 = '{1, 1};
      m_prev = 0; m_start = 0; m_tc = 0; m_lc = 0; m_phase = 0; m_wait = 0;
    end else begin
      bit s1, s2, rise, lowp;
      int nph;
      s1 = q1[0]; s2 = q2[0];
      rise = s1 && !m_prev;
      lowp = !s2;
      nph = m_phase;
      m_start = 0;
      if (m_phase == 0) begin
        m_wait = 0;
        if (lowp && (ext_clk_sel ? (m_tc >= 9) : (m_lc >= 9))) nph = 1;
      end else if (m_phase == 1) begin
        if (vpp_detect) begin nph = 2; m_start = 1; end
        else if (m_wait == TO - 1) nph = 0;
        else m_wait++;
      end
      if (m_phase != 0 || !lowp) begin m_tc = 0; m_lc = 0; end
      else begin
        if (rise && m_tc < 9) m_tc++;
        if (int_tick && m_lc < 9) m_lc++;
      end
      m_phase = nph;
      m_prev = s1;
      void'(q1.pop_front()); q1.push_back(osc1_in);
      void'(q2.pop_front()); q2.push_back(osc2_in);
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // R9: full comparison against the model on every clock
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk(cur_req, "isp_start",        isp_start,        m_start);
      chk(cur_req, "isp_active",       isp_active,       m_phase == 2);
      chk(cur_req, "reset_req",        reset_req,        m_phase != 0);
      chk(cur_req, "port_input_force", port_input_force, m_phase != 0);
      chk(cur_req, "osc2_od_en",       osc2_od_en,       m_phase != 0);
      chk(cur_req, "prog_clk_en",      prog_clk_en,      m_phase == 2);
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic pulses(int n);
    repeat (n) begin osc1_in = 1; step(2); osc1_in = 0; step(2); end
  endtask

  task automatic ticks(int n);
    repeat (n) begin int_tick = 1; step(1); int_tick = 0; step(3); end
  endtask

  task automatic do_reset();
    rst_n = 0; osc2_in = 1; osc1_in = 0; vpp_detect = 0; int_tick = 0;
    step(3); rst_n = 1; step(2);
  endtask

  task automatic armed_is(string req, logic exp);
    chk(req, "reset_req",        reset_req,        exp);
    chk(req, "port_input_force", port_input_force, exp);
    chk(req, "osc2_od_en",       osc2_od_en,       exp);
  endtask

  initial begin
    step(3);
    cmp_en = 1;
    rst_n = 1; step(2);
    cur_req = "R1";
    armed_is("R1", 0);
    chk("R1", "isp_start", isp_start, 0);
    chk("R1", "isp_active", isp_active, 0);
    chk("R1", "prog_clk_en", prog_clk_en, 0);

    cur_req = "R2";
    ext_clk_sel = 1; osc2_in = 0; step(4);
    pulses(8); step(6);
    armed_is("R2", 0);
    pulses(1); step(6);
    armed_is("R2", 1);

    cur_req = "R7";
    step(TO - 12);
    armed_is("R7", 1);
    step(12);
    armed_is("R7", 0);
    chk("R7", "isp_active", isp_active, 0);
    osc2_in = 1; step(4);

    cur_req = "R6";
    osc2_in = 0; step(4);
    pulses(9); step(6);
    armed_is("R6", 1);
    osc2_in = 1; step(3);
    vpp_detect = 1; step(1);
    chk("R6", "isp_start", isp_start, 1);
    chk("R6", "isp_active", isp_active, 1);
    vpp_detect = 0; step(1);
    chk("R6", "isp_start", isp_start, 0);
    chk("R6", "prog_clk_en", prog_clk_en, 1);
    step(TO + 5);
    chk("R6", "isp_active", isp_active, 1);
    chk("R6", "reset_req", reset_req, 1);
    do_reset();

    cur_req = "R4";
    osc2_in = 0; step(4);
    pulses(5);
    osc2_in = 1; step(4);
    osc2_in = 0; step(4);
    pulses(5); step(6);
    armed_is("R4", 0);
    pulses(4); step(6);
    armed_is("R4", 1);
    do_reset();

    cur_req = "R5";
    ext_clk_sel = 1; osc2_in = 0; step(4);
    ticks(12); step(4);
    armed_is("R5", 0);
    osc2_in = 1; step(4);
    ext_clk_sel = 0; step(1);
    osc2_in = 0; step(4);
    pulses(12); step(4);
    armed_is("R5", 0);

    cur_req = "R3";
    ticks(8); step(4);
    armed_is("R3", 0);
    ticks(1); step(4);
    armed_is("R3", 1);
    osc2_in = 1; step(2);
    vpp_detect = 1; step(1); vpp_detect = 0; step(2);
    chk("R3", "isp_active", isp_active, 1);
    do_reset();

    cur_req = "R8";
    ext_clk_sel = 1;
    vpp_detect = 1; step(10); vpp_detect = 0; step(3);
    armed_is("R8", 0);
    chk("R8", "isp_active", isp_active, 0);
    chk("R8", "isp_start", isp_start, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog %s: actual hung expected finish", cur_req);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule